// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a register-programmed master for clause-22 station management frames. Software programs a clock ratio, writes one 32-bit frame word and polls a sticky completion flag. The block sends a 32-bit preamble of ones. It then shifts the frame word out MSB first on the management data line, with the data line changing on the falling edge of the management clock. For a read frame it releases the line from the turnaround onward and samples the PHY on the rising edge. At the end of a read, the 16 received bits replace the low half of the frame word.

The frame word and the ratio may be written in either order. A frame written while the ratio is zero is held back, and it starts as soon as a non-zero ratio is written. A single select bit sends the data line either to an internal serial-link PHY (the default, which answers at PHY address 0) or to an external pin. The management clock output feeds both destinations at all times. The completion flag raises an interrupt when its mask bit is set.

The register map uses the word index on `bus_addr_i`:
- Word 0, speed: bits [5:0] hold the ratio, bit 16 is the route select.
- Word 1: the frame word.
- Word 2, event: bit 0 is the done flag, cleared by writing 1. Bit 1 is the interrupt mask.

Registers are written when `bus_we_i` is high and read back combinationally on `bus_rdata_o`.

Top module: `mdio_master`

## Requirements
- R1: While a frame runs, `mdc_o` has a period of 2*(ratio+1) clock cycles. It is low whenever no frame runs.
- R2: While the ratio is 0, `mdc_o` does not toggle and no frame is sent.
- R3: A frame written while the ratio is 0 is launched by the next write of a non-zero ratio. A frame written while the ratio is already non-zero and the block is idle is launched at once.
- R4: Each frame consists of 32 driven ones followed by frame word bits 31 down to 0. The data line changes only on falling edges of `mdc_o`, so it is stable at each rising edge.
- R5: A frame whose bits [29:28] equal 2'b10 is a read. For a read, the line is released (output enable low) for the last 18 bit periods, from frame bit 17 onward. Input bits are sampled on the rising edges of the last 16 periods, MSB first. At completion they replace frame word bits [15:0], which read back from word 1.
- R6: Completion sets event bit 0. The bit stays set until software writes 1 to event bit 0.
- R7: `irq_o` is high exactly when event bit 0 and mask bit 1 are both set.
- R8: Writing the frame word while a frame runs changes the bits still to be sent. It does not start a second frame.
- R9: With speed bit 16 at 0, the frame goes to the internal pins and the input is taken from `int_mdio_i`. With the bit at 1, the frame goes to the external pins and the input is taken from `ext_mdio_i`. The unselected output enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| mdc_o | output | 1 | Management clock, feeds both destinations |
| int_mdio_o | output | 1 | Data out to the internal PHY |
| int_mdio_oe_o | output | 1 | Output enable toward the internal PHY |
| int_mdio_i | input | 1 | Data in from the internal PHY |
| ext_mdio_o | output | 1 | Data out to the external pin |
| ext_mdio_oe_o | output | 1 | Output enable toward the external pin |
| ext_mdio_i | input | 1 | Data in from the external pin |
| irq_o | output | 1 | Masked completion interrupt |

## Verification
The scoreboard compares every bit seen at a rising `mdc_o` edge against the expected frame. The following patterns are tried:
- A write frame to the internal PHY, with the ratio written first. This shows the preamble length and the bit order.
- A read frame to the external pin, with the frame written first while the ratio is 0. This tells deferred launch from immediate launch. It also shows whether the line is released at the correct turnaround bit. The unselected pin is driven with inverted data, so a wrong input route returns the complement.
- A frame rewritten halfway through. The expected stream then switches source at a known bit, and a silent period afterwards shows that no second frame starts.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned PRE_LEN  = 32;
  localparam int unsigned BIT_CNT  = PRE_LEN + DATA_W;
  localparam int unsigned IDX_W    = $clog2(BIT_CNT);
  localparam int unsigned RD_W     = 16;
  localparam int unsigned TA_IDX   = BIT_CNT - RD_W - 2;
  localparam int unsigned RD_IDX   = BIT_CNT - RD_W;
  localparam int unsigned SEL_BIT  = 16;

  typedef enum logic [1:0] {
    REG_SPEED = 2'd0,
    REG_FRAME = 2'd1,
    REG_EVENT = 2'd2
  } reg_idx_e;

  localparam logic [1:0] OP_READ = 2'b10;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               mdc_o,
  output logic               rise_o,
  output logic               fall_o
);
  logic [RATIO_W-1:0] cnt_q;
  logic               mdc_q;
  logic               tick;

  assign tick   = run_i && (ratio_i != '0) && (cnt_q >= ratio_i);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (ratio_i != '0) begin
      if (tick) begin
        cnt_q <= '0;
        mdc_q <= !mdc_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic              din_i,
  output logic              busy_o,
  output logic              mdo_o,
  output logic              oe_o,
  output logic              done_o,
  output logic              is_read_o,
  output logic [RD_W-1:0]   rd_data_o
);
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;
  logic [RD_W-1:0]  rd_q;
  logic             last;

  assign is_read_o = (frame_i[29:28] == OP_READ);
  assign last      = (idx_q == IDX_W'(BIT_CNT - 1));
  assign busy_o    = busy_q;
  assign done_o    = busy_q && fall_i && last;
  assign rd_data_o = rd_q;

  // Frame bits come from the live register: a rewrite alters the tail.
  always_comb begin
    if (idx_q < IDX_W'(PRE_LEN)) mdo_o = 1'b1;
    else mdo_o = frame_i[~idx_q[$clog2(DATA_W)-1:0]];
    oe_o = busy_q && !(is_read_o && idx_q >= IDX_W'(TA_IDX));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else begin
      if (rise_i && idx_q >= IDX_W'(RD_IDX)) rd_q <= {rd_q[RD_W-2:0], din_i};
      if (fall_i) begin
        if (last) busy_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_route.sv
module mdio_route (
  input  logic sel_ext_i,
  input  logic mdo_i,
  input  logic oe_i,
  output logic din_o,
  output logic int_o,
  output logic int_oe_o,
  input  logic int_i,
  output logic ext_o,
  output logic ext_oe_o,
  input  logic ext_i
);
  always_comb begin
    int_o    = sel_ext_i ? 1'b1 : mdo_i;
    int_oe_o = !sel_ext_i && oe_i;
    ext_o    = sel_ext_i ? mdo_i : 1'b1;
    ext_oe_o = sel_ext_i && oe_i;
    din_o    = sel_ext_i ? ext_i : int_i;
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned RATIO_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              mdc_o,
  output logic              int_mdio_o,
  output logic              int_mdio_oe_o,
  input  logic              int_mdio_i,
  output logic              ext_mdio_o,
  output logic              ext_mdio_oe_o,
  input  logic              ext_mdio_i,
  output logic              irq_o
);
  logic [RATIO_W-1:0] ratio_q;
  logic               sel_q;
  logic [DATA_W-1:0]  frame_q;
  logic               pending_q, done_q, mask_q;
  logic               busy, start, rise, fall, done, is_read, mdo, oe, din;
  logic [RD_W-1:0]    rd_data;
  logic               wr_speed, wr_frame, wr_event;

  assign wr_speed = bus_we_i && bus_addr_i == REG_SPEED;
  assign wr_frame = bus_we_i && bus_addr_i == REG_FRAME;
  assign wr_event = bus_we_i && bus_addr_i == REG_EVENT;
  assign start    = pending_q && (ratio_q != '0) && !busy;
  assign irq_o    = done_q && mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q   <= '0;
      sel_q     <= 1'b0;
      frame_q   <= '0;
      pending_q <= 1'b0;
      done_q    <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      if (wr_speed) begin
        ratio_q <= bus_wdata_i[RATIO_W-1:0];
        sel_q   <= bus_wdata_i[SEL_BIT];
      end
      if (wr_frame) frame_q <= bus_wdata_i;
      else if (done && is_read) frame_q[RD_W-1:0] <= rd_data;
      if (wr_frame && !busy) pending_q <= 1'b1;
      else if (start) pending_q <= 1'b0;
      if (done) done_q <= 1'b1;
      else if (wr_event && bus_wdata_i[0]) done_q <= 1'b0;
      if (wr_event) mask_q <= bus_wdata_i[1];
    end
  end

  always_comb begin
    case (bus_addr_i)
      REG_SPEED: bus_rdata_o = {15'd0, sel_q, 16'(ratio_q)};
      REG_FRAME: bus_rdata_o = frame_q;
      REG_EVENT: bus_rdata_o = {30'd0, mask_q, done_q};
      default:   bus_rdata_o = '0;
    endcase
  end

  mdio_clkdiv #(.RATIO_W(RATIO_W)) i_clkdiv (
    .clk_i, .rst_ni, .run_i(busy), .ratio_i(ratio_q),
    .mdc_o, .rise_o(rise), .fall_o(fall)
  );

  mdio_shifter i_shifter (
    .clk_i, .rst_ni, .start_i(start), .rise_i(rise), .fall_i(fall),
    .frame_i(frame_q), .din_i(din), .busy_o(busy), .mdo_o(mdo), .oe_o(oe),
    .done_o(done), .is_read_o(is_read), .rd_data_o(rd_data)
  );

  mdio_route i_route (
    .sel_ext_i(sel_q), .mdo_i(mdo), .oe_i(oe), .din_o(din),
    .int_o(int_mdio_o), .int_oe_o(int_mdio_oe_o), .int_i(int_mdio_i),
    .ext_o(ext_mdio_o), .ext_oe_o(ext_mdio_oe_o), .ext_i(ext_mdio_i)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned RATIO_W = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_we_i,
  input logic [1:0]         bus_addr_i,
  input logic [31:0]        bus_wdata_i,
  input logic [RATIO_W-1:0] ratio_q,
  input logic               sel_q,
  input logic               busy,
  input logic               done,
  input logic               done_q,
  input logic               mask_q,
  input logic               mdc_o,
  input logic               int_mdio_oe_o,
  input logic               ext_mdio_oe_o,
  input logic               irq_o
);
  // R1
  mdc_idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);
  // R2
  mdc_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_q == '0) |=> $stable(mdc_o));
  // R6
  done_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> done_q);
  // R6
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !(bus_we_i && bus_addr_i == 2'd2 && bus_wdata_i[0])) |=> done_q);
  // R7
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_q |-> !irq_o);
  // R9
  route_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_q |-> !ext_mdio_oe_o);
  // R9
  route_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_q |-> !int_mdio_oe_o);
endmodule

bind mdio_master mdio_master_chk #(.RATIO_W(RATIO_W)) i_chk (
  .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i,
  .ratio_q, .sel_q, .busy, .done, .done_q, .mask_q,
  .mdc_o, .int_mdio_oe_o, .ext_mdio_oe_o, .irq_o
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, int_o, int_oe, ext_o, ext_oe, irq;
  logic        int_i, ext_i;

  int          n_chk = 0, n_fail = 0;
  logic [1:0]  exp_q[$];
  logic        sel_ext = 1'b0;
  logic [15:0] resp = '0;
  logic [5:0]  rise_cnt = '0;
  logic        d_phy;

  always #(CLK_P/2) clk = ~clk;

  mdio_master i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mdc_o(mdc),
    .int_mdio_o(int_o), .int_mdio_oe_o(int_oe), .int_mdio_i(int_i),
    .ext_mdio_o(ext_o), .ext_mdio_oe_o(ext_oe), .ext_mdio_i(ext_i),
    .irq_o(irq)
  );

  // PHY responder: data bit for the rise it is about to see; wrong pin gets inverted.
  assign d_phy = (rise_cnt >= 6'd48) ? resp[6'd63 - rise_cnt] : 1'b1;
  assign int_i = sel_ext ? ~d_phy : d_phy;
  assign ext_i = sel_ext ? d_phy : ~d_phy;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops one expected bit per MDC rising edge.
  always @(posedge mdc) begin
    logic [1:0] act, exp;
    logic oe_s, o_s, oe_u;
    oe_s = sel_ext ? ext_oe : int_oe;
    o_s  = sel_ext ? ext_o : int_o;
    oe_u = sel_ext ? int_oe : ext_oe;
    act  = {~oe_s, oe_s ? o_s : 1'b0};
    if (exp_q.size() == 0) begin
      check(1'b0, "R2/R8 unexpected MDC edge", 32'(rise_cnt), 32'hffff_ffff);
    end else begin
      exp = exp_q.pop_front();
      check(act == exp, "R4/R5 frame bit", {26'd0, rise_cnt}, 32'(exp));
      check(!oe_u, "R9 unselected oe", 32'(oe_u), 32'd0);
    end
    rise_cnt <= rise_cnt + 1'b1;
  end

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // Driver: expected bits, 2'b10 = released, else {0, value}.
  task automatic push_frame(input logic [31:0] f, input int from, input int to);
    bit rd;
    rd = (f[29:28] == 2'b10);
    for (int i = from; i <= to; i++) begin
      if (i < 32) exp_q.push_back(2'b01);
      else if (rd && i >= 46) exp_q.push_back(2'b10);
      else exp_q.push_back({1'b0, f[63-i]});
    end
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    int n = 0;
    do begin
      bus_rd(2'd2, d);
      n++;
    end while (!d[0] && n < 5000);
    check(d[0] == 1'b1, req, d, 32'd1);
    check(exp_q.size() == 0, {req, " all bits sent"}, exp_q.size(), 32'd0);
  endtask

  logic [31:0] rv;
  realtime t0, t1;
  logic [31:0] fw, fr, fa, fb;

  initial begin
    fw = {2'b01, 2'b01, 5'd0, 5'd4, 2'b10, 16'h3C5A};
    fr = {2'b01, 2'b10, 5'd7, 5'd2, 2'b11, 16'h0000};
    fa = {2'b01, 2'b01, 5'd0, 5'd1, 2'b10, 16'hFFFF};
    fb = {2'b01, 2'b01, 5'd0, 5'd1, 2'b10, 16'h0000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    bus_rd(2'd0, rv); check(rv == 32'd0, "R2 reset speed", rv, 0);
    bus_rd(2'd2, rv); check(rv == 32'd0, "R6 reset event", rv, 0);
    check(!mdc && !int_oe && !ext_oe && !irq, "R1 reset outputs", {mdc, int_oe, ext_oe, irq}, 0);

    // R3 ratio first, write frame to internal PHY, R1 period
    bus_wr(2'd0, 32'd2);
    push_frame(fw, 0, 63);
    bus_wr(2'd1, fw);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check(t1 - t0 == 6 * CLK_P, "R1 MDC period ratio 2", 32'(int'(t1 - t0)), 6 * CLK_P);
    wait_done("R3 R6 write frame done");
    bus_rd(2'd1, rv); check(rv == fw, "R5 write frame keeps data", rv, fw);
    check(!irq, "R7 irq masked", irq, 0);
    bus_wr(2'd2, 32'd2);
    #1 check(irq, "R7 irq on mask", irq, 1);
    bus_wr(2'd2, 32'd3);
    bus_rd(2'd2, rv); check(rv == 32'd2, "R6 W1C clear", rv, 2);
    check(!irq, "R7 irq after clear", irq, 0);
    bus_wr(2'd2, 32'd0);
    check(!mdc, "R1 idle low", mdc, 0);

    // R2 ratio zero holds frame, R3 deferred launch, R9 external, R5 read
    bus_wr(2'd0, 32'h0001_0000);
    sel_ext = 1'b1;
    resp = 16'hA5C3;
    bus_wr(2'd1, fr);
    repeat (100) @(negedge clk);
    check(!mdc && !ext_oe, "R2 no frame at ratio 0", {mdc, ext_oe}, 0);
    bus_rd(2'd2, rv); check(rv == 0, "R2 no done at ratio 0", rv, 0);
    push_frame(fr, 0, 63);
    bus_wr(2'd0, 32'h0001_0001);
    @(posedge mdc); t0 = $realtime;
    @(posedge mdc); t1 = $realtime;
    check(t1 - t0 == 4 * CLK_P, "R1 MDC period ratio 1", 32'(int'(t1 - t0)), 4 * CLK_P);
    wait_done("R3 deferred read done");
    bus_rd(2'd1, rv);
    check(rv == {fr[31:16], 16'hA5C3}, "R5 R9 read data from selected pin", rv, {fr[31:16], 16'hA5C3});
    bus_wr(2'd2, 32'd1);

    // R8 rewrite mid-frame, back to internal
    bus_wr(2'd0, 32'd3);
    sel_ext = 1'b0;
    push_frame(fa, 0, 40);
    push_frame(fb, 41, 63);
    bus_wr(2'd1, fa);
    wait (rise_cnt == 6'd41);
    bus_wr(2'd1, fb);
    wait_done("R8 rewritten frame done");
    bus_wr(2'd2, 32'd1);
    repeat (600) @(negedge clk);
    check(!mdc, "R8 no relaunch", mdc, 0);
    bus_rd(2'd2, rv); check(rv == 0, "R8 no second done", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule